// File: doc/BRIEF.md
# SIMD Bit-Manipulation Unit

This unit performs fixed-point bit operations on a 64-bit word in one cycle. The word can be handled as one 64-bit value or as two independent 32-bit lanes. It supports three shifts (logical left, logical right and arithmetic right), single-bit clear, set and test, and field extraction in unsigned or sign-extended form. Every operation goes through one segment-aware, one-level shifter. The shifter also produces the one-hot masks for the bit operations, and it aligns the field for extraction.

The caller presents an opcode, a lane-mode select, a data operand `opa` and an amount operand `opb`. A bit-position field and a field-width field are also supplied. Shifts read their amount from `opb`, once for each lane. Bit operations and extraction use the `pos` and `wid` fields, and both lanes share them. With the default `OUT_REG = 1`, the result and the per-lane test flags are registered and appear one clock after the inputs. With `OUT_REG = 0`, they are combinational.

Top module: `bitops_unit`

## Requirements
- R1: With `OUT_REG = 1`, `res` and `tflag` are zero while `rst_n` is low. After reset, they show the result of the inputs sampled at the previous rising clock edge.
- R2: Opcode 0 shifts left logically. In 64-bit mode (`simd` = 0) the amount is `opb[5:0]`. In SIMD mode (`simd` = 1), lane 0 (bits 31:0) shifts by `opb[4:0]` and lane 1 (bits 63:32) shifts by `opb[36:32]`.
- R3: Opcode 1 shifts right logically and fills with zeros. The amounts are taken as in R2.
- R4: Opcode 2 shifts right arithmetically. The vacated bits are filled with the sign bit of the lane: bit 63 in 64-bit mode, and bits 31 and 63 for the two lanes in SIMD mode.
- R5: Opcode 3 clears bit `pos` of `opa` in 64-bit mode. In SIMD mode it clears bit `pos[4:0]` of each lane.
- R6: Opcode 4 sets bit `pos` of `opa` in 64-bit mode. In SIMD mode it sets bit `pos[4:0]` of each lane.
- R7: Opcode 5 tests a bit. `tflag[0]` is the tested bit of the whole word or of lane 0, and `tflag[1]` is the tested bit of lane 1 (0 in 64-bit mode). The flag of each lane also appears in bit 0 of that lane of `res`, and the other result bits are 0. For every other opcode, `tflag` is 0.
- R8: Opcode 6 extracts an unsigned field. It starts at `pos` and has length `wid+1`, which is 1 to 64 in 64-bit mode, or `wid[4:0]+1`, which is 1 to 32 per lane in SIMD mode. The field is returned right-aligned in its lane, and the bits above it are zero.
- R9: Opcode 7 extracts a field as in R8, but fills the bits above the field with copies of the field's top bit.
- R10: In SIMD mode, positions and amounts are taken modulo 32. No shifted bit, mask bit or fill bit crosses between bit 31 and bit 32.
- R11: A field that would reach past the top bit of its lane is cut off at that bit. In the signed form, that top bit becomes the sign.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| op | input | 3 | Operation code (0..7, see R2..R9) |
| simd | input | 1 | 1 = two 32-bit lanes, 0 = one 64-bit word |
| opa | input | 64 | Data operand |
| opb | input | 64 | Shift amount operand (per-lane fields) |
| pos | input | 6 | Bit position / field start |
| wid | input | 6 | Field length minus one |
| res | output | 64 | Result |
| tflag | output | 2 | Per-lane bit-test flags |

## Verification
The shifts are tried with amounts of 0, 1 and the maximum, using words whose top and bottom bits are both set. This separates logical fill from arithmetic fill, and shows whether bits leak across the lane boundary. In SIMD mode the two lanes get different amounts and opposite signs, and one case sets amount bit 5, which must be ignored. The bit and field operations use positions at 0, 31, 32 and 63, a full-width field, and fields that run past the top of a lane, so that truncation and sign choice can be observed. A random sweep compared against a bit-by-bit model covers the combinations in between.

// File: rtl/bitops_unit.sv
`timescale 1ns/1ps
module bitops_unit #(
  parameter bit OUT_REG = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  op,
  input  logic        simd,
  input  logic [63:0] opa,
  input  logic [63:0] opb,
  input  logic [5:0]  pos,
  input  logic [5:0]  wid,
  output logic [63:0] res,
  output logic [1:0]  tflag
);
  localparam int DW = 64;
  localparam int LW = DW / 2;
  localparam logic [2:0] OP_SHL = 3'd0, OP_SHR = 3'd1, OP_SAR = 3'd2, OP_BCLR = 3'd3,
                         OP_BSET = 3'd4, OP_BTST = 3'd5, OP_EXTU = 3'd6, OP_EXTS = 3'd7;

  function automatic logic [DW-1:0] lane_rev(input logic [DW-1:0] d, input logic s);
    logic [DW-1:0] r;
    for (int i = 0; i < DW; i++)
      r[i] = s ? d[(i & LW) | (LW - 1 - (i & (LW - 1)))] : d[DW-1-i];
    return r;
  endfunction

  // one-level segmented right shifter: each output bit picks its source directly
  function automatic logic [DW-1:0] seg_rsh(input logic [DW-1:0] d, input logic [5:0] a_lo,
                                            input logic [4:0] a_hi, input logic f_lo,
                                            input logic f_hi, input logic s);
    logic [DW-1:0] r;
    int j, lim;
    for (int i = 0; i < DW; i++) begin
      if (s && i >= LW) begin
        j = i + int'(a_hi);
        lim = DW;
        r[i] = (j < lim) ? d[j[5:0]] : f_hi;
      end else begin
        j = i + int'(a_lo);
        lim = s ? LW : DW;
        r[i] = (j < lim) ? d[j[5:0]] : f_lo;
      end
    end
    return r;
  endfunction

  wire is_shift = (op == OP_SHL) || (op == OP_SHR) || (op == OP_SAR);
  wire is_bit   = (op == OP_BCLR) || (op == OP_BSET) || (op == OP_BTST);
  wire left     = (op == OP_SHL) || is_bit;

  wire [5:0] amt_lo = is_shift ? (simd ? {1'b0, opb[4:0]} : opb[5:0])
                               : (simd ? {1'b0, pos[4:0]} : pos);
  wire [4:0] amt_hi = is_shift ? opb[36:32] : pos[4:0];
  wire       fill_lo = (op == OP_SAR) && (simd ? opa[LW-1] : opa[DW-1]);
  wire       fill_hi = (op == OP_SAR) && opa[DW-1];

  wire [DW-1:0] sh_src = is_bit ? (simd ? {{(LW-1){1'b0}}, 1'b1, {(LW-1){1'b0}}, 1'b1}
                                        : {{(DW-1){1'b0}}, 1'b1})
                                : opa;
  wire [DW-1:0] sh_in  = left ? lane_rev(sh_src, simd) : sh_src;
  wire [DW-1:0] sh_raw = seg_rsh(sh_in, amt_lo, amt_hi, fill_lo, fill_hi, simd);
  wire [DW-1:0] sh_out = left ? lane_rev(sh_raw, simd) : sh_raw;

  wire f_lo = simd ? |(opa[LW-1:0] & sh_out[LW-1:0]) : |(opa & sh_out);
  wire f_hi = simd && |(opa[DW-1:LW] & sh_out[DW-1:LW]);

  // field length clipped to the room left in the lane
  wire [6:0] len_lo  = (simd ? {2'b0, wid[4:0]} : {1'b0, wid}) + 7'd1;
  wire [6:0] room_lo = (simd ? 7'd32 : 7'd64) - {1'b0, amt_lo};
  wire [6:0] eff_lo  = (len_lo < room_lo) ? len_lo : room_lo;
  wire [5:0] len_hi  = {1'b0, wid[4:0]} + 6'd1;
  wire [5:0] room_hi = 6'd32 - {1'b0, pos[4:0]};
  wire [5:0] eff_hi  = (len_hi < room_hi) ? len_hi : room_hi;
  wire [5:0] top_lo  = 6'(eff_lo - 7'd1);
  wire [5:0] top_hi  = 6'(LW) + (eff_hi - 6'd1);
  wire       sg_lo   = (op == OP_EXTS) && sh_out[top_lo];
  wire       sg_hi   = (op == OP_EXTS) && (simd ? sh_out[top_hi] : sh_out[top_lo]);

  logic [DW-1:0] ext;
  always_comb begin
    for (int i = 0; i < DW; i++) begin
      if (simd && i >= LW)
        ext[i] = (i - LW < int'(eff_hi)) ? sh_out[i] : sg_hi;
      else
        ext[i] = (i < int'(eff_lo)) ? sh_out[i] : sg_lo;
    end
  end

  logic [DW-1:0] nxt_res;
  logic [1:0]    nxt_flag;
  always_comb begin
    nxt_flag = 2'b00;
    case (op)
      OP_BCLR: nxt_res = opa & ~sh_out;
      OP_BSET: nxt_res = opa | sh_out;
      OP_BTST: begin
        nxt_res  = simd ? {{(LW-1){1'b0}}, f_hi, {(LW-1){1'b0}}, f_lo} : {{(DW-1){1'b0}}, f_lo};
        nxt_flag = {f_hi, f_lo};
      end
      OP_EXTU, OP_EXTS: nxt_res = ext;
      default: nxt_res = sh_out;
    endcase
  end

  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        res   <= '0;
        tflag <= '0;
      end else begin
        res   <= nxt_res;
        tflag <= nxt_flag;
      end
  end else begin : g_comb
    assign res   = nxt_res;
    assign tflag = nxt_flag;
  end
endmodule

// File: rtl/bitops_unit_chk.sv
`timescale 1ns/1ps
module bitops_unit_chk #(
  parameter bit OUT_REG = 1'b1
) (
  input logic        clk,
  input logic        rst_n,
  input logic [2:0]  op,
  input logic        simd,
  input logic [63:0] opa,
  input logic [63:0] opb,
  input logic [5:0]  pos,
  input logic [5:0]  wid,
  input logic [63:0] res,
  input logic [1:0]  tflag
);
  if (OUT_REG) begin : g_props
    p_flag_only_test_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (op != 3'd5) |=> (tflag == 2'b00));
    p_flag_hi_wide_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (op == 3'd5 && !simd) |=> (tflag[1] == 1'b0));
    p_set_only_adds_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (op == 3'd4) |=> (((res & $past(opa)) == $past(opa)) && ($countones(res ^ $past(opa)) <= 2)));
    p_clr_only_drops_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (op == 3'd3) |=> (((res | $past(opa)) == $past(opa)) && ($countones(res ^ $past(opa)) <= 2)));
    p_shl_no_gain_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (op == 3'd0) |=> ($countones(res) <= $countones($past(opa))));
    p_extu_fits_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (op == 3'd6 && !simd) |=> ((res >> ({1'b0, $past(wid)} + 7'd1)) == 64'd0));
  end
endmodule

bind bitops_unit bitops_unit_chk #(.OUT_REG(OUT_REG)) u_chk (.*);

// File: tb/sim_bitops_unit.sv
`timescale 1ns/1ps
module sim_bitops_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  op = '0;
  logic        simd = 1'b0;
  logic [63:0] opa = '0, opb = '0;
  logic [5:0]  pos = '0, wid = '0;
  logic [63:0] res;
  logic [1:0]  tflag;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  bitops_unit u0 (.clk(clk), .rst_n(rst_n), .op(op), .simd(simd), .opa(opa), .opb(opb),
                  .pos(pos), .wid(wid), .res(res), .tflag(tflag));

  function automatic void model(input logic [2:0] o, input logic s, input logic [63:0] a,
                                input logic [63:0] b, input logic [5:0] p6, input logic [5:0] w6,
                                output logic [63:0] r, output logic [1:0] f);
    int W, nl, amt, p, len, eff, base;
    r = '0; f = '0;
    W = s ? 32 : 64;
    nl = s ? 2 : 1;
    for (int L = 0; L < nl; L++) begin
      base = L * 32;
      amt  = s ? int'(b[base +: 5]) : int'(b[5:0]);
      p    = s ? int'(p6[4:0]) : int'(p6);
      len  = (s ? int'(w6[4:0]) : int'(w6)) + 1;
      eff  = (len < W - p) ? len : W - p;
      for (int i = 0; i < W; i++) begin
        case (o)
          3'd0: r[base+i] = (i >= amt) ? a[base+i-amt] : 1'b0;
          3'd1: r[base+i] = (i + amt < W) ? a[base+i+amt] : 1'b0;
          3'd2: r[base+i] = (i + amt < W) ? a[base+i+amt] : a[base+W-1];
          3'd3: r[base+i] = (i == p) ? 1'b0 : a[base+i];
          3'd4: r[base+i] = (i == p) ? 1'b1 : a[base+i];
          3'd5: r[base+i] = (i == 0) ? a[base+p] : 1'b0;
          3'd6: r[base+i] = (i < eff) ? a[base+p+i] : 1'b0;
          default: r[base+i] = (i < eff) ? a[base+p+i] : a[base+p+eff-1];
        endcase
      end
      if (o == 3'd5) f[L] = a[base+p];
    end
  endfunction

  task automatic vec(input string tag, input logic [2:0] o, input logic s, input logic [63:0] a,
                     input logic [63:0] b, input logic [5:0] p6, input logic [5:0] w6);
    logic [63:0] er;
    logic [1:0]  ef;
    @(negedge clk);
    op = o; simd = s; opa = a; opb = b; pos = p6; wid = w6;
    model(o, s, a, b, p6, w6, er, ef);
    @(negedge clk);
    n_chk++;
    if (res !== er || tflag !== ef) begin
      n_bad++;
      $display("FAIL %s op=%0d simd=%0b res=%h exp=%h tflag=%b exp=%b", tag, o, s, res, er, tflag, ef);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    op = 3'd4; opa = 64'hFFFF_0000_FFFF_0000; pos = 6'd3;
    @(negedge clk);
    n_chk++;
    if (res !== 64'd0 || tflag !== 2'b00) begin
      n_bad++;
      $display("FAIL R1 reset res=%h exp=0 tflag=%b exp=00", res, tflag);
    end
    rst_n = 1'b1;
  endtask

  task automatic t_shift();
    vec("R2 shl64", 3'd0, 1'b0, 64'h8000_0000_0000_0001, 64'd1, 6'd0, 6'd0);
    vec("R2 shl64 max", 3'd0, 1'b0, 64'h0000_0000_0000_0003, 64'd63, 6'd0, 6'd0);
    vec("R3 shr64", 3'd1, 1'b0, 64'h8000_0000_0000_0001, 64'd63, 6'd0, 6'd0);
    vec("R3 shr64 zero amt", 3'd1, 1'b0, 64'hDEAD_BEEF_0123_4567, 64'd0, 6'd0, 6'd0);
    vec("R4 sar64 neg", 3'd2, 1'b0, 64'hF000_0000_0000_00F0, 64'd4, 6'd0, 6'd0);
    vec("R4 sar64 pos", 3'd2, 1'b0, 64'h7000_0000_0000_00F0, 64'd8, 6'd0, 6'd0);
    vec("R10 shl simd", 3'd0, 1'b1, 64'h8000_0001_8000_0003, {32'd4, 32'd1}, 6'd0, 6'd0);
    vec("R10 shr simd", 3'd1, 1'b1, 64'h8000_0001_8000_0003, {32'd31, 32'd1}, 6'd0, 6'd0);
    vec("R4 sar simd", 3'd2, 1'b1, 64'h7FFF_0000_8000_0000, {32'd16, 32'd31}, 6'd0, 6'd0);
    vec("R10 amt mod32", 3'd0, 1'b1, 64'h0000_0001_0000_0001, {32'd33, 32'd34}, 6'd0, 6'd0);
  endtask

  task automatic t_bits();
    vec("R6 set 63", 3'd4, 1'b0, 64'd0, 64'd0, 6'd63, 6'd0);
    vec("R6 set 0", 3'd4, 1'b0, 64'h8000_0000_0000_0000, 64'd0, 6'd0, 6'd0);
    vec("R5 clr 32", 3'd3, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 6'd32, 6'd0);
    vec("R10 set simd", 3'd4, 1'b1, 64'd0, 64'd0, 6'd40, 6'd0);
    vec("R5 clr simd", 3'd3, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 6'd31, 6'd0);
  endtask

  task automatic t_test();
    vec("R7 test64 hit", 3'd5, 1'b0, 64'h0000_2000_0000_0000, 64'd0, 6'd45, 6'd0);
    vec("R7 test64 miss", 3'd5, 1'b0, 64'h0000_2000_0000_0000, 64'd0, 6'd44, 6'd0);
    vec("R7 test simd", 3'd5, 1'b1, 64'h8000_0000_0000_0000, 64'd0, 6'd31, 6'd0);
    vec("R7 test simd lo", 3'd5, 1'b1, 64'h0000_0000_8000_0000, 64'd0, 6'd63, 6'd0);
  endtask

  task automatic t_extract();
    vec("R8 extu byte", 3'd6, 1'b0, 64'h0000_0000_0000_AB00, 64'd0, 6'd8, 6'd7);
    vec("R9 exts byte", 3'd7, 1'b0, 64'h0000_0000_0000_AB00, 64'd0, 6'd8, 6'd7);
    vec("R8 extu full", 3'd6, 1'b0, 64'hFEDC_BA98_7654_3210, 64'd0, 6'd0, 6'd63);
    vec("R9 exts full", 3'd7, 1'b0, 64'hFEDC_BA98_7654_3210, 64'd0, 6'd0, 6'd63);
    vec("R9 exts simd", 3'd7, 1'b1, 64'h0000_0F00_0000_0700, 64'd0, 6'd8, 6'd3);
  endtask

  task automatic t_trunc();
    vec("R11 extu simd top", 3'd6, 1'b1, 64'hF000_0000_9000_0000, 64'd0, 6'd28, 6'd15);
    vec("R11 exts simd top", 3'd7, 1'b1, 64'hF000_0000_9000_0000, 64'd0, 6'd28, 6'd15);
    vec("R11 exts64 top", 3'd7, 1'b0, 64'hA000_0000_0000_0000, 64'd0, 6'd60, 6'd20);
    vec("R11 extu64 bit63", 3'd6, 1'b0, 64'h8000_0000_0000_0000, 64'd0, 6'd63, 6'd63);
  endtask

  task automatic t_random();
    for (int k = 0; k < 400; k++)
      vec("R10 random", 3'($urandom), 1'($urandom), {$urandom, $urandom}, {$urandom, $urandom},
          6'($urandom), 6'($urandom));
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_shift();
    t_bits();
    t_test();
    t_extract();
    t_trunc();
    t_random();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule